// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors and a chooser table. The first component keeps one 2-bit saturating counter per low-order PC index and records how each branch behaved in the past. The second is a correlating (2,2) predictor. It joins the low PC bits with a short global record of the latest branch outcomes, so every PC index owns one counter for each history pattern. A third table of 2-bit counters, indexed by PC, chooses which component to trust for that branch. No table stores an address tag, so branches that share low PC bits share entries.

A fetch stage drives `lk_pc` and reads back the chosen prediction, and which component produced it, in the same cycle. When a branch resolves, the execute stage presents its PC and real outcome on the update port. The counters at that PC are trained on the next clock edge. The chooser trains only when the two components disagreed, and the outcome is shifted into the global history.

Top module: `bp_tournament`

## Requirements
- R1: After the synchronous active-high reset, every counter in all three tables holds 01 and the global history holds 0. Every lookup then reports `lk_taken`=0 and `lk_use_bim`=0.
- R2: Each counter is 2 bits wide, and its upper bit is its prediction (1x = taken, 0x = not taken). An update moves it one step toward the real outcome and saturates at 00 and 11, so a strongly biased counter flips its prediction only after two mispredictions in a row.
- R3: The per-address component and the chooser are indexed by `pc[BIM_IDX_W-1:0]` and `pc[SEL_IDX_W-1:0]`, with no tag check. PCs that agree in those bits behave identically.
- R4: The correlating component is indexed by {`pc[COR_PC_W-1:0]`, history}, with the history in the low bits. An update changes only the counter selected by the current history.
- R5: Every update shifts the real outcome into bit 0 of the global history, and older outcomes move up one place. With no update the history holds its value.
- R6: A chooser counter with upper bit 1 selects the per-address component (`lk_use_bim`=1), and upper bit 0 selects the correlating component (`lk_use_bim`=0). `lk_taken` is the prediction of the selected component.
- R7: The chooser counter at the update PC changes only when the two component predictions differ. It steps up when the per-address component was right and down when the correlating component was right, and it saturates at 00 and 11.
- R8: Lookup is combinational. An update takes effect at the next rising clock edge, so a lookup in the same cycle as an update sees the state from before the update.
- R9: An update trains on the component predictions read at `upd_pc` with the history as it stands during the update cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_use_bim | output | 1 | 1 = per-address component chosen, 0 = correlating component chosen |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A lookup and an update can fall in the same cycle, and they may address the same entries. The bench provokes this by presenting an update and a lookup of the same PC together. It checks that the outputs reflect the state from before the update until the clock edge, and the trained state right after it. Long pseudo-random update streams with history-correlated outcomes follow, each followed by a lookup sweep over PCs that alias in the tables. The results are judged against a bench model of the three tables and the history, built from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  // one saturating step toward the outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'd1;
    else    r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  assign rd_a_val = mem[rd_a_idx];
  assign rd_b_val = mem[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  // R2: saturation never wraps
  assert_sat_high_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && mem[wr_idx] == 2'b11) |=> mem[$past(wr_idx)] == 2'b11);
  assert_sat_low_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up && mem[wr_idx] == 2'b00) |=> mem[$past(wr_idx)] == 2'b00);
  // R8: without a write an entry keeps its value
  assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> mem[$past(rd_b_idx)] == $past(rd_b_val));
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] nxt;

  generate
    if (HIST_W == 1) begin : g_one
      assign nxt = bit_in;
    end else begin : g_many
      assign nxt = {hist[HIST_W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= nxt;
  end

  assert_newest_lsb_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[0] == $past(bit_in));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_train.sv
module bp_train (
  input  logic valid,
  input  logic taken,
  input  logic bim_pred,
  input  logic cor_pred,
  output logic sel_we,
  output logic sel_up
);
  always_comb begin
    sel_we = valid && (bim_pred != cor_pred);
    sel_up = (bim_pred == taken);
  end
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
  import bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BIM_IDX_W = 10,
  parameter int COR_PC_W  = 9,
  parameter int SEL_IDX_W = 10,
  parameter int HIST_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_use_bim,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int COR_IDX_W = COR_PC_W + HIST_W;

  logic [HIST_W-1:0]    ghist;
  logic [BIM_IDX_W-1:0] bim_lk_idx, bim_up_idx;
  logic [COR_IDX_W-1:0] cor_lk_idx, cor_up_idx;
  logic [SEL_IDX_W-1:0] sel_lk_idx, sel_up_idx;
  ctr_t bim_lk, bim_up, cor_lk, cor_up, sel_lk, sel_up_val;
  logic bim_lk_p, cor_lk_p, bim_up_p, cor_up_p;
  logic sel_we, sel_dir;

  assign bim_lk_idx = lk_pc[BIM_IDX_W-1:0];
  assign bim_up_idx = upd_pc[BIM_IDX_W-1:0];
  assign cor_lk_idx = {lk_pc[COR_PC_W-1:0], ghist};
  assign cor_up_idx = {upd_pc[COR_PC_W-1:0], ghist};
  assign sel_lk_idx = lk_pc[SEL_IDX_W-1:0];
  assign sel_up_idx = upd_pc[SEL_IDX_W-1:0];

  bp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim (
    .clk(clk), .rst(rst),
    .rd_a_idx(bim_lk_idx), .rd_a_val(bim_lk),
    .rd_b_idx(bim_up_idx), .rd_b_val(bim_up),
    .wr_en(upd_valid), .wr_idx(bim_up_idx), .wr_up(upd_taken));

  bp_ctr_table #(.IDX_W(COR_IDX_W)) u_cor (
    .clk(clk), .rst(rst),
    .rd_a_idx(cor_lk_idx), .rd_a_val(cor_lk),
    .rd_b_idx(cor_up_idx), .rd_b_val(cor_up),
    .wr_en(upd_valid), .wr_idx(cor_up_idx), .wr_up(upd_taken));

  bp_ctr_table #(.IDX_W(SEL_IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .rd_a_idx(sel_lk_idx), .rd_a_val(sel_lk),
    .rd_b_idx(sel_up_idx), .rd_b_val(sel_up_val),
    .wr_en(sel_we), .wr_idx(sel_up_idx), .wr_up(sel_dir));

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist));

  assign bim_up_p = ctr_dir(bim_up);
  assign cor_up_p = ctr_dir(cor_up);

  bp_train u_train (
    .valid(upd_valid), .taken(upd_taken),
    .bim_pred(bim_up_p), .cor_pred(cor_up_p),
    .sel_we(sel_we), .sel_up(sel_dir));

  assign bim_lk_p   = ctr_dir(bim_lk);
  assign cor_lk_p   = ctr_dir(cor_lk);
  assign lk_use_bim = ctr_dir(sel_lk);
  assign lk_taken   = lk_use_bim ? bim_lk_p : cor_lk_p;

  // R6: when the components agree the choice cannot matter
  assert_agree_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (bim_lk_p == cor_lk_p) |-> (lk_taken == bim_lk_p));
  // R7: the chooser is left alone when both components agree
  assert_sel_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && bim_up_p == cor_up_p) |-> !sel_we);
  // R7: the chooser moves toward the correct component
  assert_sel_toward_R7: assert property (@(posedge clk) disable iff (rst)
    sel_we |-> (sel_dir == (bim_up_p == upd_taken)) && (cor_up_p != upd_taken) == sel_dir);
endmodule

// File: tb/tb_bp_tournament.sv
`timescale 1ns/1ps
module tb_bp_tournament;
  localparam int PC_W = 8, BI = 3, CI = 2, SI = 3, HW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic lk_taken, lk_use_bim;

  always #2.5 clk = ~clk;

  bp_tournament #(.PC_W(PC_W), .BIM_IDX_W(BI), .COR_PC_W(CI), .SEL_IDX_W(SI), .HIST_W(HW)) dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_use_bim(lk_use_bim),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  logic [1:0] m_bim [8];
  logic [1:0] m_cor [16];
  logic [1:0] m_sel [8];
  logic [1:0] m_gh;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [1:0] sat(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (pc %0d)", tag, act, exp, lk_pc);
    end
  endtask

  task automatic expect_pc(input int pc, input string tag);
    logic ub, bp, cp;
    lk_pc = pc[PC_W-1:0];
    #0.2;
    ub = m_sel[pc % 8][1];
    bp = m_bim[pc % 8][1];
    cp = m_cor[((pc % 4) << 2) | m_gh][1];
    chk({tag, " choice"}, lk_use_bim, ub);
    chk({tag, " taken"}, lk_taken, ub ? bp : cp);
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 16; p++) expect_pc(p, tag);
  endtask

  task automatic model_update(input int pc, input logic t);
    int bi, ci;
    logic bp, cp;
    bi = pc % 8;
    ci = ((pc % 4) << 2) | m_gh;
    bp = m_bim[bi][1];
    cp = m_cor[ci][1];
    m_bim[bi] = sat(m_bim[bi], t);
    m_cor[ci] = sat(m_cor[ci], t);
    if (bp != cp) m_sel[bi] = sat(m_sel[bi], bp == t);
    m_gh = {m_gh[0], t};
  endtask

  task automatic do_update(input int pc, input logic t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc[PC_W-1:0]; upd_taken = t;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    model_update(pc, t);
  endtask

  task automatic same_cycle(input int pc, input logic t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc[PC_W-1:0]; upd_taken = t;
    expect_pc(pc, "R8 before edge");
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    model_update(pc, t);
    expect_pc(pc, "R8,R9 after edge");
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) begin m_bim[i] = 2'b01; m_sel[i] = 2'b01; end
    for (int i = 0; i < 16; i++) m_cor[i] = 2'b01;
    m_gh = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    sweep("R1 reset");

    // R2 flip after two mispredictions, R3 aliasing via sweep over 16 pcs
    for (int k = 0; k < 4; k++) begin do_update(6, 1'b1); sweep("R2,R3"); end
    for (int k = 0; k < 3; k++) begin do_update(6, 1'b0); sweep("R2,R4"); end
    // R7 disagreement patterns on pc 5 and its alias 13
    for (int k = 0; k < 6; k++) begin do_update(5, k[0]); sweep("R7,R4"); end
    for (int k = 0; k < 6; k++) begin do_update(13, 1'b1); sweep("R7,R3"); end
    // R5 idle cycles keep history and tables
    repeat (4) @(posedge clk);
    #1 sweep("R5 idle");
    // R8 same-cycle lookup and update
    for (int k = 0; k < 8; k++) same_cycle(k * 3 % 16, k[1]);

    lfsr = 16'hACE1;
    for (int it = 0; it < 500; it++) begin
      int pc;
      logic t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = int'(lfsr[3:0]);
      t = lfsr[8] ? lfsr[5] : (lfsr[0] ^ m_gh[1]);
      do_update(pc, t);
      sweep("R4,R5,R6,R7,R9 stream");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule